// File: doc/BRIEF.md
# Operating-Point Transition Sequencer

This block moves a processor core from one operating point to another when it receives a new target frequency index. It drives a 5-bit supply code toward an off-chip regulator and a frequency select toward the clock generator. A small computed lookup gives the lowest supply code each frequency index may run at. Index 0 is the slowest point, about 200 MHz, and each index above it adds about 33 MHz. Two handshake inputs stand in for the analog parts: a regulator-ready level and a PLL lock level.

When the target is faster, the sequencer raises the supply one code at a time. After each code it waits for a settle interval, and it changes the frequency only once the final code has settled. When the target is slower, it changes the frequency first and waits for the PLL to lock. Only then does it walk the supply down. In both directions the frequency select moves once, directly to the target. The core is told to stall only while the PLL is relocking. A lock watchdog bounds that wait. If the watchdog expires, a sticky error is raised and the stall is dropped. A request that arrives while a transition is running is held and served once the sequencer is idle again.

Top module: `dvfs_opp_sequencer`

## Requirements
- R1: For a higher target index T, the supply code steps upward to 1 + 2*T before the frequency select changes, and at every cycle the supply code is at least 1 + 2*(current frequency select).
- R2: For a lower target index T, the frequency select changes first. The supply code only starts to fall, toward 1 + 2*T, after the stall has ended on a seen PLL lock.
- R3: Each transition changes the frequency select exactly once, straight to the target. The supply code moves by exactly one code per change, and the supply and frequency never change in the same cycle.
- R4: After every supply-code change, at least SETTLE_CYC+1 clock cycles pass before the next supply change or an upward frequency change.
- R5: `core_stall_o` rises in the cycle the frequency select changes and falls in the cycle after `pll_lock` is sampled high. It is never high while the supply code changes, and a transition that does not change the frequency never stalls.
- R6: After reset the supply code is 1, the frequency select is 0, and stall, busy and the error flag are low.
- R7: A request that arrives during a transition is held, and a later one replaces it. The held request starts only when the running transition has fully finished.
- R8: If lock is not seen within LOCK_TO cycles of the frequency change, the stall ends and `lock_err_o` is set. The sequencer returns to idle without lowering the supply. The flag stays set until reset. A lock seen in the expiry cycle itself counts as a lock.
- R9: While `vreg_ok` is low, no supply step and no upward frequency change takes place.
- R10: A request equal to the current frequency index changes nothing and never raises busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Pulse carrying a new target index |
| req_fidx | input | FIDX_W | Target frequency index |
| vreg_ok | input | 1 | Regulator reports output in range |
| pll_lock | input | 1 | PLL reports lock at current select |
| vcode_o | output | VCODE_W | Supply code to the regulator |
| fsel_o | output | FIDX_W | Frequency select to the clock generator |
| core_stall_o | output | 1 | Core must hold while PLL relocks |
| busy_o | output | 1 | A transition is in progress |
| lock_err_o | output | 1 | Sticky lock-timeout flag |

## Verification
The lock watchdog can expire in the same cycle that the PLL lock is first sampled, so the two exits from the relock state meet on one edge. The bench's PLL model delays lock by a programmable number of cycles after every frequency change. With a delay of LOCK_TO-2, lock arrives exactly on the expiry edge, and the bench expects a clean exit with no error and a stall of LOCK_TO cycles. One cycle more of delay must produce the error with the same stall length.

// File: rtl/dvfs_opp_pkg.sv
package dvfs_opp_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_RAISE  = 2'd1,
    SEQ_RELOCK = 2'd2,
    SEQ_LOWER  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/opp_req_latch.sv
// Holds the most recent target index until the sequencer takes it.
module opp_req_latch #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             take_i,
  output logic             pend_v_o,
  output logic [IDX_W-1:0] pend_idx_o
);

  logic             pend_v_q, pend_v_n;
  logic [IDX_W-1:0] pend_idx_q, pend_idx_n;
  logic             idx_en;

  always_comb begin
    // a fresh request in the take cycle stays pending
    pend_v_n   = req_valid | (pend_v_q & ~take_i);
    idx_en     = req_valid;
    pend_idx_n = req_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q   <= 1'b0;
      pend_idx_q <= '0;
    end else begin
      pend_v_q <= pend_v_n;
      if (idx_en) pend_idx_q <= pend_idx_n;
    end
  end

  assign pend_v_o   = pend_v_q;
  assign pend_idx_o = pend_idx_q;

endmodule

// File: rtl/opp_vmin_map.sv
// Lowest permitted supply code for a frequency index (linear map).
module opp_vmin_map #(
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned CODE_W    = 5,
  parameter int unsigned V_FLOOR   = 1,
  parameter int unsigned V_PER_IDX = 2
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [CODE_W-1:0] code_o
);

  localparam int unsigned TOP_CODE = V_FLOOR + V_PER_IDX * ((1 << IDX_W) - 1);
  localparam bit          FITS     = (TOP_CODE < (1 << CODE_W));

  generate
    if (FITS) begin : g_linear
      assign code_o = CODE_W'(V_FLOOR + V_PER_IDX * int'(idx_i));
    end else begin : g_saturate
      logic [31:0] raw;
      assign raw    = 32'(V_FLOOR) + 32'(V_PER_IDX) * 32'(idx_i);
      assign code_o = (raw > 32'((1 << CODE_W) - 1)) ? '1 : CODE_W'(raw);
    end
  endgenerate

endmodule

// File: rtl/opp_countdown.sv
// Loadable down-counter; zero_o high once the loaded interval has run out.
module opp_countdown #(
  parameter int unsigned LOAD_VAL = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic zero_o
);

  localparam int unsigned CW = (LOAD_VAL < 1) ? 1 : $clog2(LOAD_VAL + 1);
  localparam logic [CW-1:0] LOADV = CW'(LOAD_VAL);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i | (cnt_q != '0);
    cnt_n  = load_i ? LOADV : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/dvfs_opp_sequencer.sv
module dvfs_opp_sequencer
  import dvfs_opp_pkg::*;
#(
  parameter int unsigned FIDX_W     = 4,
  parameter int unsigned VCODE_W    = 5,
  parameter int unsigned V_FLOOR    = 1,
  parameter int unsigned V_PER_IDX  = 2,
  parameter int unsigned SETTLE_CYC = 6,
  parameter int unsigned LOCK_TO    = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [FIDX_W-1:0]  req_fidx,
  input  logic               vreg_ok,
  input  logic               pll_lock,
  output logic [VCODE_W-1:0] vcode_o,
  output logic [FIDX_W-1:0]  fsel_o,
  output logic               core_stall_o,
  output logic               busy_o,
  output logic               lock_err_o
);

  localparam logic [VCODE_W-1:0] VCODE_RST = VCODE_W'(V_FLOOR);
  localparam int unsigned        WD_LOAD   = (LOCK_TO < 2) ? 0 : LOCK_TO - 1;

  seq_state_e         state_q, state_n;
  logic [VCODE_W-1:0] vcode_q, vcode_n;
  logic [FIDX_W-1:0]  fsel_q, fsel_n;
  logic [FIDX_W-1:0]  tgt_q, tgt_n;
  logic               down_q, down_n;
  logic               err_q, err_set;

  logic               pend_v;
  logic [FIDX_W-1:0]  pend_idx;
  logic               take_req;
  logic [VCODE_W-1:0] vmin_tgt;
  logic               settle_load, settle_done;
  logic               wd_load, wd_expired;

  opp_req_latch #(.IDX_W(FIDX_W)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_idx    (req_fidx),
    .take_i     (take_req),
    .pend_v_o   (pend_v),
    .pend_idx_o (pend_idx)
  );

  opp_vmin_map #(
    .IDX_W     (FIDX_W),
    .CODE_W    (VCODE_W),
    .V_FLOOR   (V_FLOOR),
    .V_PER_IDX (V_PER_IDX)
  ) u_vmin (
    .idx_i  (tgt_q),
    .code_o (vmin_tgt)
  );

  opp_countdown #(.LOAD_VAL(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (settle_load),
    .zero_o (settle_done)
  );

  opp_countdown #(.LOAD_VAL(WD_LOAD)) u_lock_wd (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (wd_load),
    .zero_o (wd_expired)
  );

  // next-state logic
  always_comb begin
    state_n     = state_q;
    vcode_n     = vcode_q;
    fsel_n      = fsel_q;
    tgt_n       = tgt_q;
    down_n      = down_q;
    err_set     = 1'b0;
    take_req    = 1'b0;
    settle_load = 1'b0;
    wd_load     = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (pend_v) begin
          take_req = 1'b1;
          tgt_n    = pend_idx;
          if (pend_idx > fsel_q) begin
            down_n  = 1'b0;
            state_n = SEQ_RAISE;
          end else if (pend_idx < fsel_q) begin
            // slowing down: clock first, supply after lock
            down_n  = 1'b1;
            fsel_n  = pend_idx;
            wd_load = 1'b1;
            state_n = SEQ_RELOCK;
          end
        end
      end
      SEQ_RAISE: begin
        if (settle_done && vreg_ok) begin
          if (vcode_q < vmin_tgt) begin
            vcode_n     = vcode_q + 1'b1;
            settle_load = 1'b1;
          end else begin
            fsel_n  = tgt_q;
            wd_load = 1'b1;
            state_n = SEQ_RELOCK;
          end
        end
      end
      SEQ_RELOCK: begin
        // lock takes priority over a watchdog expiring on the same edge
        if (pll_lock) begin
          state_n = down_q ? SEQ_LOWER : SEQ_IDLE;
        end else if (wd_expired) begin
          err_set = 1'b1;
          state_n = SEQ_IDLE;
        end
      end
      SEQ_LOWER: begin
        if (settle_done && vreg_ok) begin
          if (vcode_q > vmin_tgt) begin
            vcode_n     = vcode_q - 1'b1;
            settle_load = 1'b1;
          end else begin
            state_n = SEQ_IDLE;
          end
        end
      end
      default: state_n = SEQ_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      vcode_q <= VCODE_RST;
      fsel_q  <= '0;
      tgt_q   <= '0;
      down_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      vcode_q <= vcode_n;
      fsel_q  <= fsel_n;
      if (take_req) begin
        tgt_q  <= tgt_n;
        down_q <= down_n;
      end
      if (err_set) err_q <= 1'b1;
    end
  end

  assign vcode_o      = vcode_q;
  assign fsel_o       = fsel_q;
  assign core_stall_o = (state_q == SEQ_RELOCK);
  assign busy_o       = (state_q != SEQ_IDLE);
  assign lock_err_o   = err_q;

endmodule

// File: rtl/dvfs_opp_seq_checker.sv
module dvfs_opp_seq_checker #(
  parameter int unsigned FIDX_W    = 4,
  parameter int unsigned VCODE_W   = 5,
  parameter int unsigned V_FLOOR   = 1,
  parameter int unsigned V_PER_IDX = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [VCODE_W-1:0] vcode_o,
  input logic [FIDX_W-1:0]  fsel_o,
  input logic               core_stall_o,
  input logic               busy_o,
  input logic               lock_err_o
);

  // R1 and R2: supply always covers the running frequency
  assert_vcode_covers_fsel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vcode_o) >= int'(V_FLOOR) + int'(V_PER_IDX) * int'(fsel_o));

  assert_vcode_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vcode_o != $past(vcode_o)) |->
      ((vcode_o == $past(vcode_o) + 1'b1) || ($past(vcode_o) == vcode_o + 1'b1)));

  assert_one_move_per_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !((vcode_o != $past(vcode_o)) && (fsel_o != $past(fsel_o))));

  assert_fsel_move_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel_o != $past(fsel_o)) |-> core_stall_o);

  assert_stall_holds_vcode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall_o |-> $stable(vcode_o));

  assert_stall_inside_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall_o |-> busy_o);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_err_o) |-> lock_err_o);

endmodule

bind dvfs_opp_sequencer dvfs_opp_seq_checker #(
  .FIDX_W    (FIDX_W),
  .VCODE_W   (VCODE_W),
  .V_FLOOR   (V_FLOOR),
  .V_PER_IDX (V_PER_IDX)
) u_seq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .vcode_o      (vcode_o),
  .fsel_o       (fsel_o),
  .core_stall_o (core_stall_o),
  .busy_o       (busy_o),
  .lock_err_o   (lock_err_o)
);

// File: tb/dvfs_opp_sequencer_bench.sv
module dvfs_opp_sequencer_bench;

  localparam int FIDX_W  = 4;
  localparam int VCODE_W = 5;
  localparam int V_FLOOR = 1;
  localparam int V_PER   = 2;
  localparam int SETTLE  = 6;
  localparam int LOCK_TO = 24;
  localparam int NVEC    = 9;

  // {target index, PLL lock delay}
  localparam logic [11:0] VEC [NVEC] = '{
    {4'd5,  8'd3}, {4'd15, 8'd0}, {4'd15, 8'd2}, {4'd2, 8'd5}, {4'd9, 8'd1},
    {4'd0,  8'd4}, {4'd1, 8'd10}, {4'd14, 8'd7}, {4'd3, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [FIDX_W-1:0] req_fidx = '0;
  logic vreg_ok = 1'b1;
  logic pll_lock;
  logic [VCODE_W-1:0] vcode_o;
  logic [FIDX_W-1:0] fsel_o;
  logic core_stall_o, busy_o, lock_err_o;

  always #5 clk = ~clk;

  dvfs_opp_sequencer #(
    .FIDX_W(FIDX_W), .VCODE_W(VCODE_W), .V_FLOOR(V_FLOOR), .V_PER_IDX(V_PER),
    .SETTLE_CYC(SETTLE), .LOCK_TO(LOCK_TO)
  ) u_dvfs_opp_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fidx(req_fidx),
    .vreg_ok(vreg_ok), .pll_lock(pll_lock), .vcode_o(vcode_o), .fsel_o(fsel_o),
    .core_stall_o(core_stall_o), .busy_o(busy_o), .lock_err_o(lock_err_o)
  );

  // PLL model: lock drops when the select moves, returns lock_dly cycles later
  logic [FIDX_W-1:0] seen_f;
  logic [7:0] lcnt;
  logic [7:0] lock_dly = 8'd0;
  logic nolock = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_f <= '0;
      lcnt   <= 8'd0;
    end else if (fsel_o != seen_f) begin
      seen_f <= fsel_o;
      lcnt   <= lock_dly;
    end else if (lcnt != 8'd0) begin
      lcnt <= lcnt - 8'd1;
    end
  end
  assign pll_lock = !nolock && (fsel_o == seen_f) && (lcnt == 8'd0);

  int n_chk = 0, n_fail = 0;
  int n_vchg, n_fchg, n_stall, n_busy, gap_cnt, gap_bad, order_bad, stall_v_bad, f_max;
  int inv_bad = 0;
  bit dir_up;
  logic [VCODE_W-1:0] prev_v;
  logic [FIDX_W-1:0] prev_f;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_v = vcode_o;
      prev_f = fsel_o;
    end else begin
      if (int'(vcode_o) < V_FLOOR + V_PER * int'(fsel_o)) inv_bad++;
      if (core_stall_o) n_stall++;
      if (busy_o) n_busy++;
      if (fsel_o != prev_f) begin
        n_fchg++;
        if (dir_up && gap_cnt < SETTLE) gap_bad++;
        if (int'(fsel_o) > f_max) f_max = int'(fsel_o);
      end
      if (vcode_o != prev_v) begin
        n_vchg++;
        if (gap_cnt < SETTLE) gap_bad++;
        if (dir_up && n_fchg != 0) order_bad++;
        if (!dir_up && (n_fchg == 0 || core_stall_o)) order_bad++;
        if (core_stall_o) stall_v_bad++;
        gap_cnt = 0;
      end else begin
        gap_cnt++;
      end
      prev_v = vcode_o;
      prev_f = fsel_o;
    end
  end

  task automatic check_eq(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic clear_mon(input int tgt);
    n_vchg = 0; n_fchg = 0; n_stall = 0; n_busy = 0; gap_cnt = 1000;
    gap_bad = 0; order_bad = 0; stall_v_bad = 0; f_max = int'(fsel_o);
    dir_up = (tgt > int'(fsel_o));
  endtask

  task automatic wait_idle();
    int quiet = 0;
    int guard = 0;
    while (quiet < 3 && guard < 5000) begin
      @(negedge clk);
      if (!busy_o) quiet++; else quiet = 0;
      guard++;
    end
  endtask

  task automatic send(input int tgt);
    req_valid = 1'b1;
    req_fidx  = FIDX_W'(tgt);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic run_req(input int tgt, input int dly);
    lock_dly = 8'(dly);
    @(posedge clk); #1;
    clear_mon(tgt);
    send(tgt);
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got %0d cycles expected fewer", 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_eq("R6 vcode", int'(vcode_o), 1);
    check_eq("R6 fsel", int'(fsel_o), 0);
    check_eq("R6 stall", int'(core_stall_o), 0);
    check_eq("R6 busy", int'(busy_o), 0);
    check_eq("R6 lock_err", int'(lock_err_o), 0);

    for (int i = 0; i < NVEC; i++) begin
      int tgt, dly, cur, vold, vnew, dv;
      string rq;
      tgt  = int'(VEC[i][11:8]);
      dly  = int'(VEC[i][7:0]);
      cur  = int'(fsel_o);
      vold = V_FLOOR + V_PER * cur;
      vnew = V_FLOOR + V_PER * tgt;
      dv   = (vnew > vold) ? vnew - vold : vold - vnew;
      rq   = (tgt > cur) ? "R1" : (tgt < cur) ? "R2" : "R10";
      run_req(tgt, dly);
      check_eq({rq, " final vcode"}, int'(vcode_o), vnew);
      check_eq({rq, " final fsel"}, int'(fsel_o), tgt);
      check_eq({rq, " ordering"}, order_bad, 0);
      check_eq("R3 supply steps", n_vchg, dv);
      check_eq("R3 frequency moves", n_fchg, (tgt != cur) ? 1 : 0);
      check_eq("R4 settle spacing", gap_bad, 0);
      check_eq("R5 stall cycles", n_stall, (tgt != cur) ? dly + 2 : 0);
      check_eq("R5 supply move while stalled", stall_v_bad, 0);
      if (tgt == cur) check_eq("R10 busy cycles", n_busy, 0);
    end

    // R7: requests during a running transition, latest one wins
    lock_dly = 8'd2;
    @(posedge clk); #1;
    clear_mon(12);
    send(12);
    repeat (5) @(posedge clk);
    #1 send(1);
    send(6);
    wait_idle();
    check_eq("R7 first target reached", f_max, 12);
    check_eq("R7 frequency moves", n_fchg, 2);
    check_eq("R7 final fsel", int'(fsel_o), 6);
    check_eq("R7 final vcode", int'(vcode_o), 13);

    // R9: regulator not ready holds the raise
    vreg_ok = 1'b0;
    lock_dly = 8'd1;
    @(posedge clk); #1;
    clear_mon(10);
    send(10);
    repeat (30) @(negedge clk);
    check_eq("R9 vcode held", int'(vcode_o), 13);
    check_eq("R9 fsel held", int'(fsel_o), 6);
    check_eq("R9 busy", int'(busy_o), 1);
    @(posedge clk); #1 vreg_ok = 1'b1;
    wait_idle();
    check_eq("R9 final vcode", int'(vcode_o), 21);
    check_eq("R9 final fsel", int'(fsel_o), 10);

    // R8: lock arriving on the watchdog expiry edge is a lock
    run_req(4, LOCK_TO - 2);
    check_eq("R8 boundary no error", int'(lock_err_o), 0);
    check_eq("R8 boundary stall cycles", n_stall, LOCK_TO);
    check_eq("R8 boundary vcode lowered", int'(vcode_o), 9);

    // R8: one cycle later times out
    run_req(8, LOCK_TO - 1);
    check_eq("R8 timeout error", int'(lock_err_o), 1);
    check_eq("R8 timeout stall cycles", n_stall, LOCK_TO);
    check_eq("R8 stall released", int'(core_stall_o), 0);
    check_eq("R8 idle after timeout", int'(busy_o), 0);
    check_eq("R8 fsel", int'(fsel_o), 8);

    // R8: downward with no lock keeps supply high
    nolock = 1'b1;
    run_req(2, 0);
    check_eq("R8 supply not lowered", int'(vcode_o), 17);
    check_eq("R8 fsel after no-lock", int'(fsel_o), 2);
    check_eq("R8 no-lock stall cycles", n_stall, LOCK_TO);

    // R8: flag stays set across a clean transition
    nolock = 1'b0;
    run_req(5, 0);
    check_eq("R8 sticky error", int'(lock_err_o), 1);
    check_eq("R8 fsel after recovery", int'(fsel_o), 5);
    check_eq("R1 no steps needed vcode", int'(vcode_o), 17);
    check_eq("R5 recovery stall cycles", n_stall, 2);

    check_eq("R1 supply covers frequency", inv_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule